// File: doc/BRIEF.md
# Unaligned Load Splitter and Merger

This block serves a processor load port that may ask for a byte, a halfword or a word at any byte address, in front of a read-only bus that only moves whole, word-aligned 32-bit words. It works out whether the wanted bytes sit inside one bus word or span two. It then issues one aligned read, or two reads one after the other, and keeps only the byte lanes it needs from each returned word.

The kept bytes are joined in little-endian order (lowest address in lane 0) and returned right-justified. Byte and halfword results are widened to 32 bits with zeros or with copies of their top bit, chosen by a signed flag. With the result comes a one-cycle done strobe and a beat count of 1 or 2, so the caller can see what the access cost on the bus. One load is in flight at a time; a new one is taken only when the block is idle.

Top module: `ld_align_merge`

## Requirements
- R1: A byte load (size code 00) at any lane offset 0..3 uses exactly one bus read and returns that lane's byte in result bits 7:0.
- R2: A halfword load (size code 01) at lane offset 0, 1 or 2 uses one bus read; result bits 7:0 hold the byte at the request address and bits 15:8 the byte at the next address.
- R3: A halfword load at lane offset 3 uses two bus reads: the low result byte comes from lane 3 of the first word and the high result byte from lane 0 of the following word.
- R4: A word load (size code 10) at lane offset 0 uses one bus read; at offsets 1, 2 or 3 it uses two, with the upper lanes of the first word forming the low part of the result and the lower lanes of the next word forming the high part.
- R5: Every bus read address has bits 1:0 cleared; the first equals the request address with bits 1:0 cleared and the second equals the first plus 4, wrapping modulo 2^32.
- R6: At most one bus read is outstanding: the second read is requested only after the response to the first has been taken.
- R7: With the signed flag set, byte and halfword results fill the upper bits with their top bit; with it clear the upper bits are zero; word results ignore the flag.
- R8: After reset and whenever idle, the request ready output is high, and it stays low from acceptance until the load completes; a request presented while busy is not taken and does not change the current result.
- R9: The done output is high for exactly one cycle, the cycle after the final bus response is sampled, and carries a beat count of 1 or 2 equal to the number of bus reads used; done is low after reset.
- R10: A bus read request, once raised, holds its valid and address unchanged until the bus accepts it.
- R11: Size code 11 is handled exactly as a word load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Load request present |
| ld_ready | output | 1 | Block idle, request will be taken |
| ld_addr | input | 32 | Byte address of the load |
| ld_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| ld_signed | input | 1 | Sign-extend byte/halfword results |
| rd_valid | output | 1 | Bus read request valid |
| rd_ready | input | 1 | Bus accepts the read request |
| rd_addr | output | 32 | Word-aligned bus read address |
| rsp_valid | input | 1 | Bus read data present |
| rsp_data | input | 32 | Bus read data, lane 0 in bits 7:0 |
| ld_done | output | 1 | One-cycle completion strobe |
| ld_result | output | 32 | Merged, extended load data |
| ld_beats | output | 2 | Bus reads used (1 or 2) |

## Verification
A request taken at a clock edge raises the bus read valid from that same edge, and the read is accepted at the first edge where the bus ready is seen; each response is sampled one edge after the bench drives it. The done strobe, result and beat count are registered, so they appear exactly one edge after the last response is sampled, and the bench confirms this by comparing the cycle of done against the cycle in which it drove the final response. The bench's bus model drives ready and data on falling edges and all outputs are read on falling edges, so every check lands midway between the edge that produced the value and the next one, including under stalled ready and delayed responses.

// File: rtl/ldam_pkg.sv
package ldam_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_HALF  = 2'b01,
    SZ_WORD  = 2'b10,
    SZ_WORDX = 2'b11
  } ld_size_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ_A,
    ST_WAIT_A,
    ST_REQ_B,
    ST_WAIT_B
  } ld_state_e;

endpackage

// File: rtl/ldam_decode.sv
module ldam_decode
  import ldam_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LANES  = 4,
  localparam int OFF_W = $clog2(LANES),
  localparam int NB_W  = $clog2(LANES) + 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic [ADDR_W-1:0] word_addr,
  output logic [OFF_W-1:0]  lane_off,
  output logic [NB_W-1:0]   nbytes,
  output logic              crosses
);

  logic [NB_W:0] span;

  always_comb begin
    word_addr = {addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    lane_off  = addr[OFF_W-1:0];
    case (ld_size_e'(size))
      SZ_BYTE: nbytes = NB_W'(1);
      SZ_HALF: nbytes = NB_W'(2);
      default: nbytes = NB_W'(LANES);
    endcase
    span    = {{(NB_W + 1 - OFF_W){1'b0}}, lane_off} + {1'b0, nbytes};
    crosses = span > (NB_W + 1)'(LANES);
  end

endmodule

// File: rtl/ldam_merge.sv
module ldam_merge #(
  parameter int LANES  = 4,
  localparam int DATA_W = 8 * LANES,
  localparam int OFF_W  = $clog2(LANES),
  localparam int NB_W   = $clog2(LANES) + 1
) (
  input  logic [DATA_W-1:0] lo_word,
  input  logic [DATA_W-1:0] hi_word,
  input  logic [OFF_W-1:0]  lane_off,
  input  logic [NB_W-1:0]   nbytes,
  input  logic              sext,
  output logic [DATA_W-1:0] merged
);

  logic [2*DATA_W-1:0] joined;
  logic                top_bit;
  logic                fill;

  always_comb begin
    joined = {hi_word, lo_word} >> {lane_off, 3'b000};
    case (nbytes)
      NB_W'(1): top_bit = joined[7];
      NB_W'(2): top_bit = joined[15];
      default:  top_bit = 1'b0;
    endcase
    fill = sext & top_bit;
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign merged[8*k +: 8] = (NB_W'(k) < nbytes) ? joined[8*k +: 8] : {8{fill}};
  end

endmodule

// File: rtl/ldam_ctrl.sv
module ldam_ctrl
  import ldam_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ld_valid,
  input  logic crosses,
  input  logic rd_ready,
  input  logic rsp_valid,
  output logic ld_ready,
  output logic accept,
  output logic rd_valid,
  output logic second,
  output logic cap_first,
  output logic finish
);

  ld_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (ld_valid)  state_d = ST_REQ_A;
      ST_REQ_A:  if (rd_ready)  state_d = ST_WAIT_A;
      ST_WAIT_A: if (rsp_valid) state_d = crosses ? ST_REQ_B : ST_IDLE;
      ST_REQ_B:  if (rd_ready)  state_d = ST_WAIT_B;
      ST_WAIT_B: if (rsp_valid) state_d = ST_IDLE;
      default:                  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    ld_ready  = (state_q == ST_IDLE);
    accept    = ld_ready & ld_valid;
    rd_valid  = (state_q == ST_REQ_A) | (state_q == ST_REQ_B);
    second    = (state_q == ST_REQ_B) | (state_q == ST_WAIT_B);
    cap_first = (state_q == ST_WAIT_A) & rsp_valid & crosses;
    finish    = rsp_valid & (((state_q == ST_WAIT_A) & ~crosses) | (state_q == ST_WAIT_B));
  end

  // R8
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_ready) |=> !ld_ready);

  // R6
  one_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready) |=> !rd_valid);

endmodule

// File: rtl/ld_align_merge.sv
module ld_align_merge
  import ldam_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LANES  = 4,
  localparam int DATA_W = 8 * LANES,
  localparam int OFF_W  = $clog2(LANES),
  localparam int NB_W   = $clog2(LANES) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [1:0]        ld_size,
  input  logic              ld_signed,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              ld_done,
  output logic [DATA_W-1:0] ld_result,
  output logic [1:0]        ld_beats
);

  logic              accept, second, cap_first, finish;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        size_q;
  logic              sgn_q;
  logic [ADDR_W-1:0] word_a;
  logic [OFF_W-1:0]  lane_off;
  logic [NB_W-1:0]   nbytes;
  logic              crosses;
  logic [DATA_W-1:0] first_q;
  logic [DATA_W-1:0] lo_word, hi_word, merged;
  logic [DATA_W-1:0] result_q;
  logic              done_q;
  logic [1:0]        beats_q;

  ldam_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_valid  (ld_valid),
    .crosses   (crosses),
    .rd_ready  (rd_ready),
    .rsp_valid (rsp_valid),
    .ld_ready  (ld_ready),
    .accept    (accept),
    .rd_valid  (rd_valid),
    .second    (second),
    .cap_first (cap_first),
    .finish    (finish)
  );

  ldam_decode #(.ADDR_W(ADDR_W), .LANES(LANES)) u_decode (
    .addr      (addr_q),
    .size      (size_q),
    .word_addr (word_a),
    .lane_off  (lane_off),
    .nbytes    (nbytes),
    .crosses   (crosses)
  );

  // request capture, enabled on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      size_q <= '0;
      sgn_q  <= 1'b0;
    end else if (accept) begin
      addr_q <= ld_addr;
      size_q <= ld_size;
      sgn_q  <= ld_signed;
    end
  end

  // first word of a split access
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         first_q <= '0;
    else if (cap_first) first_q <= rsp_data;
  end

  always_comb begin
    rd_addr = second ? (word_a + ADDR_W'(LANES)) : word_a;
    lo_word = crosses ? first_q  : rsp_data;
    hi_word = crosses ? rsp_data : '0;
  end

  ldam_merge #(.LANES(LANES)) u_merge (
    .lo_word  (lo_word),
    .hi_word  (hi_word),
    .lane_off (lane_off),
    .nbytes   (nbytes),
    .sext     (sgn_q),
    .merged   (merged)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      beats_q  <= 2'd0;
    end else if (finish) begin
      result_q <= merged;
      beats_q  <= crosses ? 2'd2 : 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= finish;
  end

  assign ld_done   = done_q;
  assign ld_result = result_q;
  assign ld_beats  = beats_q;

  // R5
  addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_addr[OFF_W-1:0] == '0));

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_done |=> !ld_done);

  // R9
  beats_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_done |-> (ld_beats == 2'd1 || ld_beats == 2'd2));

  // R1
  byte_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_done && size_q == 2'b00) |-> (ld_beats == 2'd1));

endmodule

// File: tb/ld_align_merge_tb.sv
`timescale 1ns/1ps
module ld_align_merge_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ld_valid, ld_ready, ld_signed;
  logic [31:0] ld_addr;
  logic [1:0]  ld_size;
  logic        rd_valid, rd_ready;
  logic [31:0] rd_addr;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        ld_done;
  logic [31:0] ld_result;
  logic [1:0]  ld_beats;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  // bus model state
  int          ready_stall = 0;
  int          rsp_lat     = 0;
  int          stall_left  = 0;
  int          lat_left    = 0;
  logic        rsp_pend    = 1'b0;
  logic        outstanding = 1'b0;
  logic [31:0] pend_addr;
  logic [31:0] hs_log [4];
  int          n_hs        = 0;
  int          r6_viol     = 0;
  int          last_rsp_cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ld_align_merge u_dut (
    .clk(clk), .rst_n(rst_n),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr),
    .ld_size(ld_size), .ld_signed(ld_signed),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .ld_done(ld_done), .ld_result(ld_result), .ld_beats(ld_beats)
  );

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    return 8'(a[7:0] * 8'd37) + a[15:8] + 8'h5B;
  endfunction

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {mem_byte(a + 3), mem_byte(a + 2), mem_byte(a + 1), mem_byte(a)};
  endfunction

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // bus responder: everything driven on falling edges
  initial begin
    rd_ready  = 1'b0;
    rsp_valid = 1'b0;
    rsp_data  = '0;
    forever begin
      @(negedge clk);
      rsp_valid = 1'b0;
      if (rsp_pend) begin
        if (lat_left == 0) begin
          rsp_valid    = 1'b1;
          rsp_data     = mem_word(pend_addr);
          rsp_pend     = 1'b0;
          outstanding  = 1'b0;
          last_rsp_cyc = cyc;
        end else begin
          lat_left--;
        end
      end
      if (rd_valid) begin
        if (stall_left > 0) begin
          rd_ready = 1'b0;
          stall_left--;
        end else begin
          rd_ready = 1'b1;
          if (outstanding) r6_viol++;
          outstanding = 1'b1;
          if (n_hs < 4) hs_log[n_hs] = rd_addr;
          n_hs++;
          pend_addr = rd_addr;
          rsp_pend  = 1'b1;
          lat_left  = rsp_lat;
        end
      end else begin
        rd_ready   = 1'b0;
        stall_left = ready_stall;
      end
    end
  end

  // issue one load and check everything it produces; busy_poke adds a request while busy
  task automatic do_load(input logic [31:0] a, input logic [1:0] sz, input logic sg,
                         input string tag, input logic busy_poke);
    int          n;
    logic [31:0] exp;
    logic        topb;
    int          exp_beats;
    logic [31:0] w0;
    int          done_cyc;
    logic        seen;
    n = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
    exp = '0;
    for (int i = 0; i < n; i++) exp[8*i +: 8] = mem_byte(a + i);
    topb = exp[8*n-1];
    if (sg && n < 4) for (int i = 8*n; i < 32; i++) exp[i] = topb;
    exp_beats = ((a[1:0] + n) > 4) ? 2 : 1;
    w0 = {a[31:2], 2'b00};
    n_hs = 0;
    r6_viol = 0;
    @(negedge clk);
    ld_valid = 1'b1; ld_addr = a; ld_size = sz; ld_signed = sg;
    @(negedge clk);
    if (busy_poke) begin
      ld_addr = a ^ 32'h0000_0F03; ld_size = 2'b10; ld_signed = ~sg;
      check(ld_ready == 1'b0, {tag, " R8 ready low while busy"}, 32'(ld_ready), 32'd0);
      @(negedge clk);
      check(ld_ready == 1'b0, {tag, " R8 ready low while busy"}, 32'(ld_ready), 32'd0);
    end
    ld_valid = 1'b0;
    seen = 1'b0;
    done_cyc = 0;
    for (int t = 0; t < 60 && !seen; t++) begin
      if (ld_done) begin
        seen = 1'b1;
        done_cyc = cyc;
      end else begin
        @(negedge clk);
      end
    end
    check(seen, {tag, " R9 done seen"}, 32'(seen), 32'd1);
    if (seen) begin
      check(ld_result == exp, {tag, " result"}, ld_result, exp);
      check(ld_beats == 2'(exp_beats), {tag, " R9 beats"}, 32'(ld_beats), 32'(exp_beats));
      check(n_hs == exp_beats, {tag, " bus read count"}, 32'(n_hs), 32'(exp_beats));
      check(hs_log[0] == w0, {tag, " R5 first address"}, hs_log[0], w0);
      if (exp_beats == 2)
        check(hs_log[1] == w0 + 32'd4, {tag, " R5 second address"}, hs_log[1], w0 + 32'd4);
      check(r6_viol == 0, {tag, " R6 single outstanding"}, 32'(r6_viol), 32'd0);
      check(done_cyc == last_rsp_cyc + 1, {tag, " R9 done timing"}, 32'(done_cyc), 32'(last_rsp_cyc + 1));
      @(negedge clk);
      check(ld_done == 1'b0, {tag, " R9 done one cycle"}, 32'(ld_done), 32'd0);
      check(ld_ready == 1'b1, {tag, " R8 ready when idle"}, 32'(ld_ready), 32'd1);
    end
  endtask

  task automatic t_reset();
    check(ld_ready == 1'b1, "R8 reset ready", 32'(ld_ready), 32'd1);
    check(rd_valid == 1'b0, "R10 reset no bus read", 32'(rd_valid), 32'd0);
    check(ld_done == 1'b0, "R9 reset done low", 32'(ld_done), 32'd0);
  endtask

  task automatic t_bytes();
    for (int o = 0; o < 4; o++) begin
      do_load(32'h0000_1230 + 32'(o), 2'b00, 1'b0, "R1 byte unsigned", 1'b0);
      do_load(32'h0000_1330 + 32'(o), 2'b00, 1'b1, "R7 byte signed", 1'b0);
    end
  endtask

  task automatic t_halves();
    for (int o = 0; o < 3; o++) begin
      do_load(32'h0000_2000 + 32'(o), 2'b01, 1'b0, "R2 half in word", 1'b0);
      do_load(32'h0000_2104 + 32'(o), 2'b01, 1'b1, "R7 half signed", 1'b0);
    end
    do_load(32'h0000_2203, 2'b01, 1'b0, "R3 half split", 1'b0);
    do_load(32'h0000_2307, 2'b01, 1'b1, "R3 half split signed", 1'b0);
  endtask

  task automatic t_words();
    for (int o = 0; o < 4; o++) begin
      do_load(32'h0000_3010 + 32'(o), 2'b10, 1'b1, "R4 word", 1'b0);
    end
    do_load(32'h0000_3402, 2'b11, 1'b1, "R11 size 11 split", 1'b0);
    do_load(32'h0000_3500, 2'b11, 1'b0, "R11 size 11 aligned", 1'b0);
  endtask

  task automatic t_wrap();
    do_load(32'hFFFF_FFFE, 2'b10, 1'b0, "R5 word wraps", 1'b0);
    do_load(32'hFFFF_FFFF, 2'b01, 1'b1, "R5 half wraps", 1'b0);
  endtask

  task automatic t_stall();
    ready_stall = 3; rsp_lat = 4;
    do_load(32'h0000_4001, 2'b10, 1'b0, "R10 stalled split word", 1'b0);
    do_load(32'h0000_4102, 2'b01, 1'b1, "R6 stalled half", 1'b0);
    ready_stall = 0; rsp_lat = 0;
  endtask

  task automatic t_busy();
    rsp_lat = 3;
    do_load(32'h0000_5003, 2'b01, 1'b1, "R8 poke while busy", 1'b1);
    rsp_lat = 0;
    do_load(32'h0000_5101, 2'b00, 1'b0, "R8 after poke", 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual %0d expected done", cyc);
    summary();
  end

  initial begin
    rst_n = 1'b0;
    ld_valid = 1'b0; ld_addr = '0; ld_size = '0; ld_signed = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bytes();
    t_halves();
    t_words();
    t_wrap();
    t_stall();
    t_busy();
    repeat (2) @(negedge clk);
    summary();
  end

endmodule